// File: doc/BRIEF.md
# Three-Phase Hall Commutation Decoder

This block converts three Hall position sensors, spaced 120 electrical degrees apart, into six switch commands for a three-phase inverter: one high-side and one low-side command per phase. A direction input selects which way torque is applied. Brake, coast, a quadrant-mode select, the PWM on/off state, an overcurrent trip and an undervoltage flag decide which of the decoded commands reach the pins.

The Hall lines are asynchronous. They pass through a two-flop synchronizer and then a stability filter. After that they are decoded. Every other input is a single-bit logic level that is synchronous to `clk`. Analog comparators produce these inputs outside the block. The six commands leave through one output register. A control input therefore shows on the pins one clock after the edge that samples it.

The overcurrent trip is held until the next PWM period begins. While it is held, it forces the PWM-off state. All pins are plain levels and there is no handshake.

Top module: `bldc_commutator`

## Requirements
- R1: With `dir_fwd`=1 and a valid code written `hall_in[2:0]` = A,B,C, the drive is as follows. Output bit 0 is phase A, bit 1 is phase B and bit 2 is phase C.

  | Code | High side | Low side |
  |------|-----------|----------|
  | 101  | A         | B        |
  | 100  | A         | C        |
  | 110  | B         | C        |
  | 010  | B         | A        |
  | 011  | C         | A        |
  | 001  | C         | B        |

  Motoring forward steps through these codes in the order 101, 100, 110, 010, 011, 001.
- R2: With `dir_fwd`=0, each valid code drives the same two phases as in R1, but with the high and low sides exchanged.
- R3: When the filtered Hall code is 000 or 111 and brake is not active, all six outputs are 0.
- R4: `coast_cmd`=1 forces all six outputs to 0. This holds even when brake is active.
- R5: `brake_cmd`=1 forces all high-side outputs to 0. It sets all three low-side outputs to 1 when the PWM is on, no overcurrent is held, and neither coast nor undervoltage is active. The Hall code has no effect during brake.
- R6: During brake, each of PWM-off, an overcurrent trip and undervoltage turns the low-side outputs off.
- R7: With `quad_sel`=0 and PWM off, the active high-side output stays on and the low-side outputs are all 0.
- R8: With `quad_sel`=1 and PWM off, all six outputs are 0.
- R9: `uvlo`=1 forces all six outputs to 0, one clock after it is sampled.
- R10: An `oc_trip` pulse forces the PWM-off state from the edge that samples it. The state stays forced while the PWM input remains on, until a `period_start` pulse arrives. After that pulse the outputs return.
- R11: A change in the Hall lines that lasts fewer than `FILT_CNT` clocks has no effect on the outputs. A change that is held steady reaches the outputs within 12 clocks, with the default parameters.
- R12: High-side and low-side outputs are never both on for the same phase. In motoring, at most one high-side output and at most one low-side output are on.
- R13: During reset, and just after it, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hall_in | input | 3 | Raw Hall lines: bit 2 = A, bit 1 = B, bit 0 = C |
| dir_fwd | input | 1 | 1 = forward torque, 0 = reverse |
| brake_cmd | input | 1 | Brake request |
| coast_cmd | input | 1 | Coast request; turns off all outputs |
| quad_sel | input | 1 | 0 = chop low side only, 1 = chop both sides |
| pwm_on | input | 1 | PWM comparator state; 1 = on time |
| period_start | input | 1 | One-cycle pulse at the start of each PWM period |
| oc_trip | input | 1 | Overcurrent comparator output |
| uvlo | input | 1 | Undervoltage lockout flag |
| gate_hi | output | 3 | High-side commands; bit 0 = A, bit 1 = B, bit 2 = C |
| gate_lo | output | 3 | Low-side commands; bit 0 = A, bit 1 = B, bit 2 = C |

## Verification
The hardest case to reach from the ports is a held overcurrent that outlives its trip pulse. To reach it, the stimulus drops `oc_trip` after one clock, keeps PWM on, and checks that the outputs stay off for several clocks. It then sends a `period_start` pulse and checks that the outputs come back. The glitch filter is tested in a similar way: a one-clock excursion on the Hall lines must leave the outputs unchanged, and the same code held steady must then be accepted.

// File: rtl/bldc_comm_pkg.sv
package bldc_comm_pkg;

  typedef struct packed {
    logic [2:0] hi;
    logic [2:0] lo;
  } gate_pair_t;

  // Hall code (A,B,C) to forward drive pair; 000/111 give no drive
  function automatic gate_pair_t fwd_pair(input logic [2:0] code);
    gate_pair_t p;
    p = '0;
    case (code)
      3'b101: begin p.hi = 3'b001; p.lo = 3'b010; end
      3'b100: begin p.hi = 3'b001; p.lo = 3'b100; end
      3'b110: begin p.hi = 3'b010; p.lo = 3'b100; end
      3'b010: begin p.hi = 3'b010; p.lo = 3'b001; end
      3'b011: begin p.hi = 3'b100; p.lo = 3'b001; end
      3'b001: begin p.hi = 3'b100; p.lo = 3'b010; end
      default: p = '0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/hall_filter.sv
module hall_filter #(
  parameter int NBITS    = 3,
  parameter int FILT_CNT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] raw,
  output logic [NBITS-1:0] clean
);
  localparam int CW = $clog2(FILT_CNT + 1);

  logic [NBITS-1:0] s1, s2, cand;
  logic [CW-1:0]    cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; cand <= '0; cnt <= '0; clean <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      if (s2 != cand) begin
        cand <= s2;
        cnt  <= '0;
      end else if (cnt != CW'(FILT_CNT)) begin
        cnt <= cnt + 1'b1;
      end else begin
        clean <= cand;
      end
    end
  end

  // R11: a fresh disagreement never updates the filtered code on the next edge
  assert_glitch_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (s2 != cand) |=> $stable(clean));

endmodule

// File: rtl/oc_hold.sv
module oc_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_trip,
  input  logic period_start,
  output logic oc_block
);
  logic held;

  always_ff @(posedge clk) begin
    if (!rst_n)            held <= 1'b0;
    else if (oc_trip)      held <= 1'b1;
    else if (period_start) held <= 1'b0;
  end

  assign oc_block = held | oc_trip;

  // R10: a trip is remembered on the following cycle
  assert_trip_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    oc_trip |=> held);
  // R10: held state persists until a period start
  assert_hold_until_period_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !period_start) |=> held);

endmodule

// File: rtl/comm_gate.sv
module comm_gate
  import bldc_comm_pkg::*;
#(
  parameter int NPH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     hall_code,
  input  logic           dir_fwd,
  input  logic           brake_cmd,
  input  logic           coast_cmd,
  input  logic           quad_sel,
  input  logic           pwm_on,
  input  logic           oc_block,
  input  logic           uvlo,
  output logic [NPH-1:0] gate_hi,
  output logic [NPH-1:0] gate_lo
);
  gate_pair_t fp;
  logic [NPH-1:0] sel_hi, sel_lo, nxt_hi, nxt_lo;
  logic pwm_eff, kill;

  always_comb begin
    fp     = fwd_pair(hall_code);
    sel_hi = dir_fwd ? fp.hi : fp.lo;
    sel_lo = dir_fwd ? fp.lo : fp.hi;
  end

  assign pwm_eff = pwm_on & ~oc_block;
  assign kill    = uvlo | coast_cmd;

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    always_comb begin
      if (kill) begin
        nxt_hi[p] = 1'b0;
        nxt_lo[p] = 1'b0;
      end else if (brake_cmd) begin
        nxt_hi[p] = 1'b0;
        nxt_lo[p] = pwm_eff;
      end else begin
        nxt_hi[p] = sel_hi[p] & (quad_sel ? pwm_eff : 1'b1);
        nxt_lo[p] = sel_lo[p] & pwm_eff;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_hi <= '0;
      gate_lo <= '0;
    end else begin
      gate_hi <= nxt_hi;
      gate_lo <= nxt_lo;
    end
  end

  // R12: no phase has both switches on
  assert_no_shoot_through_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi & gate_lo) == '0);
  // R12: at most one high-side command at a time
  assert_single_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gate_hi));
  // R9: undervoltage clears every output
  assert_uvlo_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> (gate_hi == '0 && gate_lo == '0));
  // R4: coast clears every output
  assert_coast_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    coast_cmd |=> (gate_hi == '0 && gate_lo == '0));
  // R5: brake never drives a high side
  assert_brake_no_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    brake_cmd |=> gate_hi == '0);
  // R8: four-quadrant PWM-off clears both sides
  assert_quad_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (quad_sel && !pwm_on) |=> (gate_hi == '0 && gate_lo == '0));

endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator #(
  parameter int FILT_CNT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hall_in,
  input  logic       dir_fwd,
  input  logic       brake_cmd,
  input  logic       coast_cmd,
  input  logic       quad_sel,
  input  logic       pwm_on,
  input  logic       period_start,
  input  logic       oc_trip,
  input  logic       uvlo,
  output logic [2:0] gate_hi,
  output logic [2:0] gate_lo
);
  logic [2:0] hall_clean;
  logic       oc_block;

  hall_filter #(.NBITS(3), .FILT_CNT(FILT_CNT)) u_filt (
    .clk(clk), .rst_n(rst_n), .raw(hall_in), .clean(hall_clean)
  );

  oc_hold u_oc (
    .clk(clk), .rst_n(rst_n), .oc_trip(oc_trip),
    .period_start(period_start), .oc_block(oc_block)
  );

  comm_gate #(.NPH(3)) u_gate (
    .clk(clk), .rst_n(rst_n), .hall_code(hall_clean), .dir_fwd(dir_fwd),
    .brake_cmd(brake_cmd), .coast_cmd(coast_cmd), .quad_sel(quad_sel),
    .pwm_on(pwm_on), .oc_block(oc_block), .uvlo(uvlo),
    .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

endmodule

// File: tb/bldc_commutator_test.sv
module bldc_commutator_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] hall_in = 3'b000;
  logic dir_fwd = 1'b1, brake_cmd = 1'b0, coast_cmd = 1'b0, quad_sel = 1'b0;
  logic pwm_on = 1'b1, period_start = 1'b0, oc_trip = 1'b0, uvlo = 1'b0;
  logic [2:0] gate_hi, gate_lo;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct {
    logic [2:0] hi;
    logic [2:0] lo;
    string      tag;
  } exp_t;
  exp_t sb[$];
  event sample_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  bldc_commutator uut (
    .clk(clk), .rst_n(rst_n), .hall_in(hall_in), .dir_fwd(dir_fwd),
    .brake_cmd(brake_cmd), .coast_cmd(coast_cmd), .quad_sel(quad_sel),
    .pwm_on(pwm_on), .period_start(period_start), .oc_trip(oc_trip),
    .uvlo(uvlo), .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  // forward drive pairs from R1 (bit0=A, bit1=B, bit2=C)
  function automatic logic [5:0] ref_pair(input logic [2:0] c, input logic fwd);
    logic [2:0] h, l;
    case (c)
      3'b101: begin h = 3'b001; l = 3'b010; end
      3'b100: begin h = 3'b001; l = 3'b100; end
      3'b110: begin h = 3'b010; l = 3'b100; end
      3'b010: begin h = 3'b010; l = 3'b001; end
      3'b011: begin h = 3'b100; l = 3'b001; end
      3'b001: begin h = 3'b100; l = 3'b010; end
      default: begin h = 3'b000; l = 3'b000; end
    endcase
    return fwd ? {h, l} : {l, h};
  endfunction

  // driver side: wait, then queue the expectation and wake the monitor
  task automatic expect_after(input int ncyc, input logic [2:0] eh,
                              input logic [2:0] el, input string tag);
    exp_t e;
    repeat (ncyc) @(posedge clk);
    #1;
    e.hi = eh; e.lo = el; e.tag = tag;
    sb.push_back(e);
    -> sample_ev;
    #1;
  endtask

  // monitor: pop and compare
  initial begin
    forever begin
      exp_t e;
      @(sample_ev);
      while (sb.size() > 0) begin
        e = sb.pop_front();
        checks++;
        if (gate_hi !== e.hi || gate_lo !== e.lo) begin
          fails++;
          $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b",
                   e.tag, gate_hi, gate_lo, e.hi, e.lo);
        end
        checks++;
        if ((gate_hi & gate_lo) !== 3'b000) begin
          fails++;
          $display("FAIL R12: hi=%b lo=%b overlap expected none", gate_hi, gate_lo);
        end
      end
    end
  end

  task automatic set_hall(input logic [2:0] c);
    @(negedge clk); hall_in = c;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    logic [2:0] seq [6] = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};
    logic [5:0] p;
    repeat (3) @(posedge clk);
    #1;
    expect_after(0, 3'b000, 3'b000, "R13 in reset");
    @(negedge clk); rst_n = 1'b1;
    expect_after(1, 3'b000, 3'b000, "R13 after reset");

    // R1: forward table
    for (int i = 0; i < 6; i++) begin
      set_hall(seq[i]);
      p = ref_pair(seq[i], 1'b1);
      expect_after(12, p[5:3], p[2:0], "R1 forward decode");
    end
    // R2: reverse
    @(negedge clk); dir_fwd = 1'b0;
    for (int i = 0; i < 6; i += 2) begin
      set_hall(seq[i]);
      p = ref_pair(seq[i], 1'b0);
      expect_after(12, p[5:3], p[2:0], "R2 reverse decode");
    end
    @(negedge clk); dir_fwd = 1'b1;
    // R3: invalid codes
    set_hall(3'b000);
    expect_after(12, 3'b000, 3'b000, "R3 code 000");
    set_hall(3'b111);
    expect_after(12, 3'b000, 3'b000, "R3 code 111");

    set_hall(3'b101);
    expect_after(12, 3'b001, 3'b010, "R1 code 101");
    // R11: one-cycle glitch ignored
    set_hall(3'b110);
    set_hall(3'b101);
    expect_after(12, 3'b001, 3'b010, "R11 glitch ignored");
    set_hall(3'b110);
    expect_after(12, 3'b010, 3'b100, "R11 steady change taken");
    set_hall(3'b101);
    expect_after(12, 3'b001, 3'b010, "R1 code 101 again");

    // R7 / R8: PWM off in each quadrant mode
    @(negedge clk); pwm_on = 1'b0; quad_sel = 1'b0;
    expect_after(3, 3'b001, 3'b000, "R7 two-quadrant pwm off");
    @(negedge clk); quad_sel = 1'b1;
    expect_after(3, 3'b000, 3'b000, "R8 four-quadrant pwm off");
    @(negedge clk); pwm_on = 1'b1;
    expect_after(3, 3'b001, 3'b010, "R8 four-quadrant pwm on");

    // R5 / R6: brake
    @(negedge clk); brake_cmd = 1'b1;
    expect_after(3, 3'b000, 3'b111, "R5 brake low sides on");
    set_hall(3'b111);
    expect_after(12, 3'b000, 3'b111, "R5 brake ignores hall");
    @(negedge clk); pwm_on = 1'b0;
    expect_after(3, 3'b000, 3'b000, "R6 brake pwm off");
    @(negedge clk); pwm_on = 1'b1; oc_trip = 1'b1;
    expect_after(2, 3'b000, 3'b000, "R6 brake overcurrent");
    @(negedge clk); oc_trip = 1'b0; period_start = 1'b1;
    @(negedge clk); period_start = 1'b0;
    expect_after(3, 3'b000, 3'b111, "R5 brake restored");
    @(negedge clk); uvlo = 1'b1;
    expect_after(3, 3'b000, 3'b000, "R6 brake uvlo");
    @(negedge clk); uvlo = 1'b0; coast_cmd = 1'b1;
    expect_after(3, 3'b000, 3'b000, "R4 coast over brake");
    @(negedge clk); brake_cmd = 1'b0;
    set_hall(3'b010);
    expect_after(12, 3'b000, 3'b000, "R4 coast motoring");
    @(negedge clk); coast_cmd = 1'b0;
    expect_after(3, 3'b010, 3'b001, "R1 code 010 after coast");

    // R9
    @(negedge clk); uvlo = 1'b1;
    expect_after(2, 3'b000, 3'b000, "R9 uvlo");
    @(negedge clk); uvlo = 1'b0;
    expect_after(3, 3'b010, 3'b001, "R9 uvlo released");

    // R10: held overcurrent, quad=1
    @(negedge clk); oc_trip = 1'b1;
    @(negedge clk); oc_trip = 1'b0;
    expect_after(1, 3'b000, 3'b000, "R10 trip blocks");
    expect_after(6, 3'b000, 3'b000, "R10 still held");
    @(negedge clk); period_start = 1'b1;
    @(negedge clk); period_start = 1'b0;
    expect_after(3, 3'b010, 3'b001, "R10 released at period start");

    expect_after(2, 3'b010, 3'b001, "R12 final state");
    finish_run();
  end

endmodule